// File: doc/BRIEF.md
# Three-Lane 7:1 Pixel Serializer

This block packs one pixel per pixel-clock period into a narrow serial link. Each pixel word is 21 bits wide: eighteen colour bits (six each for red, green and blue) and three timing bits (line sync, frame sync and data enable). The block takes the word on the falling edge of the pixel clock. It then spreads the bits over three serial data lanes, seven bit slots per lane in each pixel period. A fourth lane sends a fixed seven-slot clock pattern. A receiver uses that pattern to recover word framing.

All logic runs on a bit clock at seven times the pixel rate. The pixel clock is sampled as an ordinary input in that domain, and its falling edge is detected there. The captured word goes into a hold register, so a stable copy is ready when the shifters reload at the start of each seven-slot frame. An active-low power-down input releases every lane to high impedance. This is shown by a single output-enable line that the pad drivers use. When power-down is lifted, the lanes stay released until a complete frame has been loaded.

The pad drivers, the clock multiplier and the electrical levels are outside this block. The intended pixel rate is 20 to 65 MHz, which gives up to 455 Mbit/s per lane.

Top module: `pxl_link_ser`

## Requirements
- R1: The word captured is the one on `pix_word` at the first bit-clock edge that sees `pix_clk` low after an edge that saw it high. A change made half a bit clock before that edge is captured.
- R2: Lane mapping: `lane_dat[0]` carries word bits [6:0], `lane_dat[1]` carries bits [13:7] and `lane_dat[2]` carries bits [20:14]. Each lane sends its least significant bit in slot 0 and its most significant bit in slot 6.
- R3: `lane_clk` sends the slot sequence 1,1,0,0,0,1,1 for slots 0 to 6 in every frame. As a vector with bit k equal to slot k, this is 7'b1100011. It lines up slot for slot with the data lanes.
- R4: Slot 0 of a captured word is driven from the first bit-clock edge after the capture edge. Slot k is driven k edges later, and each slot lasts one bit clock.
- R5: Changes on `pix_word` after the capture edge have no effect on the frame being sent. That frame carries the captured word.
- R6: While `pd_n` is low, `lane_oe` is 0 from the next bit-clock edge onward (all lanes at high impedance). `lane_dat` and `lane_clk` are 0 while `lane_oe` is 0.
- R7: After `pd_n` returns high, `lane_oe` stays 0 until a word has been captured with `pd_n` high and loaded into the shifters. It rises with slot 0 of that word.
- R8: During reset and after reset until the first frame is loaded, `lane_oe` is 0 and all lane outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock, seven times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pix_clk | input | 1 | Pixel clock, sampled in the bit-clock domain; its falling edge strobes the word |
| pd_n | input | 1 | Active-low power-down |
| pix_word | input | 21 | Pixel word: colour bits and line sync, frame sync, data enable |
| lane_dat | output | 3 | Serial data lanes |
| lane_clk | output | 1 | Serial clock-pattern lane |
| lane_oe | output | 1 | Lane drive enable; 0 means all lanes at high impedance |

## Verification
A slot counter that is out of phase with the pixel clock would shift the clock-lane pattern against the data. That shows up as a wrong pattern within the first frame, at most seven bit clocks after the fault. A stale or overwritten hold register shows up as wrong data from slot 0 of the affected frame, one bit clock after the capture edge. A mistake in the enable sequencing appears either on the bit-clock edge right after power-down is asserted, or as an enable that rises one pixel period too early or never rises after release.

// File: rtl/pxl_link_pkg.sv
package pxl_link_pkg;
  localparam int unsigned LANES_DEF = 3;
  localparam int unsigned SLOTS_DEF = 7;
  // slot k of the clock lane is bit k
  localparam logic [SLOTS_DEF-1:0] CLK_PAT_DEF = 7'b1100011;
endpackage

// File: rtl/pxl_rst_sync.sv
module pxl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/pxl_slot_timer.sv
module pxl_slot_timer #(
  parameter int unsigned N_SLOTS = 7,
  localparam int unsigned SW = $clog2(N_SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_clk,
  output logic          cap_stb,
  output logic          load_stb,
  output logic [SW-1:0] slot_cnt
);
  localparam logic [SW-1:0] LAST = SW'(N_SLOTS - 1);

  logic          pix_q;
  logic [SW-1:0] cnt_q, cnt_d;

  // falling edge of the pixel clock seen in the bit domain
  assign cap_stb = pix_q & ~pix_clk;

  always_comb begin
    if (cap_stb)            cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q <= 1'b0;
      cnt_q <= LAST;
    end else begin
      pix_q <= pix_clk;
      cnt_q <= cnt_d;
    end
  end

  assign load_stb = (cnt_q == '0);
  assign slot_cnt = cnt_q;

  // R4
  load_follows_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |=> load_stb);
endmodule

// File: rtl/pxl_lane_shift.sv
module pxl_lane_shift #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] par,
  output logic         ser
);
  logic [W-1:0] sh_q, sh_d;

  always_comb begin
    if (load) sh_d = par;
    else      sh_d = {1'b0, sh_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign ser = sh_q[0];
endmodule

// File: rtl/pxl_link_ser.sv
module pxl_link_ser
  import pxl_link_pkg::*;
#(
  parameter int unsigned N_LANES = LANES_DEF,
  parameter int unsigned N_SLOTS = SLOTS_DEF,
  parameter logic [N_SLOTS-1:0] CLK_PAT = CLK_PAT_DEF,
  localparam int unsigned WORD_W = N_LANES * N_SLOTS,
  localparam int unsigned SW = $clog2(N_SLOTS)
) (
  input  logic               clk_bit,
  input  logic               rst_n,
  input  logic               pix_clk,
  input  logic               pd_n,
  input  logic [WORD_W-1:0]  pix_word,
  output logic [N_LANES-1:0] lane_dat,
  output logic               lane_clk,
  output logic               lane_oe
);
  logic              srst_n;
  logic              cap_stb, load_stb;
  logic [SW-1:0]     slot_cnt;
  logic [WORD_W-1:0] hold_q, hold_d;
  logic              fresh_q, fresh_d;
  logic              oe_q, oe_d;
  logic [N_LANES-1:0] ser_dat;
  logic               ser_clk;
  logic [N_LANES-1:0] lsb_vec;

  pxl_rst_sync u_rst (
    .clk    (clk_bit),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  pxl_slot_timer #(.N_SLOTS(N_SLOTS)) u_timer (
    .clk      (clk_bit),
    .rst_n    (srst_n),
    .pix_clk  (pix_clk),
    .cap_stb  (cap_stb),
    .load_stb (load_stb),
    .slot_cnt (slot_cnt)
  );

  // capture stage: the shifters reload from this copy
  always_comb begin
    hold_d = cap_stb ? pix_word : hold_q;
  end

  // enable sequencing around power-down
  always_comb begin
    fresh_d = fresh_q;
    oe_d    = oe_q;
    if (!pd_n) begin
      fresh_d = 1'b0;
      oe_d    = 1'b0;
    end else begin
      if (cap_stb)            fresh_d = 1'b1;
      if (load_stb && fresh_q) oe_d   = 1'b1;
    end
  end

  always_ff @(posedge clk_bit or negedge srst_n) begin
    if (!srst_n) begin
      hold_q  <= '0;
      fresh_q <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      fresh_q <= fresh_d;
      oe_q    <= oe_d;
    end
  end

  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    pxl_lane_shift #(.W(N_SLOTS)) u_shift (
      .clk   (clk_bit),
      .rst_n (srst_n),
      .load  (load_stb),
      .par   (hold_q[i*N_SLOTS +: N_SLOTS]),
      .ser   (ser_dat[i])
    );
    assign lsb_vec[i] = hold_q[i*N_SLOTS];
  end

  pxl_lane_shift #(.W(N_SLOTS)) u_clk_lane (
    .clk   (clk_bit),
    .rst_n (srst_n),
    .load  (load_stb),
    .par   (CLK_PAT),
    .ser   (ser_clk)
  );

  assign lane_oe  = oe_q;
  assign lane_dat = oe_q ? ser_dat : '0;
  assign lane_clk = oe_q & ser_clk;

  // slot shown on the lanes lags the counter by one
  logic [SW-1:0] shown_slot;
  always_comb begin
    shown_slot = (slot_cnt == '0) ? SW'(N_SLOTS - 1) : slot_cnt - 1'b1;
  end

  // R3
  clk_lane_pattern_chk: assert property (@(posedge clk_bit) disable iff (!srst_n)
    lane_oe |-> lane_clk == CLK_PAT[shown_slot]);

  // R2
  lane_lsb_first_chk: assert property (@(posedge clk_bit) disable iff (!srst_n)
    (lane_oe && slot_cnt == SW'(1)) |-> lane_dat == $past(lsb_vec));

  // R6
  pd_release_chk: assert property (@(posedge clk_bit) disable iff (!srst_n)
    !pd_n |=> !lane_oe);

  // R7
  oe_rise_on_load_chk: assert property (@(posedge clk_bit) disable iff (!srst_n)
    $rose(lane_oe) |-> $past(load_stb) && $past(pd_n));
endmodule

// File: tb/pxl_link_ser_bench.sv
module pxl_link_ser_bench;
  logic        clk_bit;
  logic        rst_n;
  logic        pix_clk;
  logic        pd_n;
  logic [20:0] pix_word;
  logic [2:0]  lane_dat;
  logic        lane_clk;
  logic        lane_oe;

  int ph;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [6:0] CLK_EXP = 7'b1100011;

  pxl_link_ser u_pxl_link_ser (
    .clk_bit  (clk_bit),
    .rst_n    (rst_n),
    .pix_clk  (pix_clk),
    .pd_n     (pd_n),
    .pix_word (pix_word),
    .lane_dat (lane_dat),
    .lane_clk (lane_clk),
    .lane_oe  (lane_oe)
  );

  // 100 MHz bit clock
  initial begin
    clk_bit = 1'b0;
    forever #5 clk_bit = ~clk_bit;
  end

  // pixel clock at 1/7 rate: high for phases 0..3, low for 4..6
  initial begin
    ph = 0;
    pix_clk = 1'b1;
    forever begin
      @(posedge clk_bit);
      #2;
      ph = (ph == 6) ? 0 : ph + 1;
      pix_clk = (ph < 4);
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic wait_ph(input int p);
    do @(negedge clk_bit); while (ph != p);
  endtask

  task automatic gather(output logic [6:0] g0, output logic [6:0] g1,
                        output logic [6:0] g2, output logic [6:0] gc,
                        output logic all_oe);
    wait_ph(6);
    all_oe = 1'b1;
    for (int k = 0; k < 7; k++) begin
      if (k > 0) @(negedge clk_bit);
      g0[k] = lane_dat[0];
      g1[k] = lane_dat[1];
      g2[k] = lane_dat[2];
      gc[k] = lane_clk;
      all_oe &= lane_oe;
    end
  endtask

  task automatic check_frame(input string tag, input logic [20:0] w);
    logic [6:0] g0, g1, g2, gc;
    logic       all_oe;
    gather(g0, g1, g2, gc, all_oe);
    chk({tag, " R2 R4 lane0"}, 32'(g0), 32'(w[6:0]));
    chk({tag, " R2 R4 lane1"}, 32'(g1), 32'(w[13:7]));
    chk({tag, " R2 R4 lane2"}, 32'(g2), 32'(w[20:14]));
    chk({tag, " R3 clock lane"}, 32'(gc), 32'(CLK_EXP));
    chk({tag, " enable over frame"}, 32'(all_oe), 32'd1);
  endtask

  task automatic send(input logic [20:0] w);
    wait_ph(0);
    pix_word = w;
    check_frame("stream", w);
  endtask

  // R8: outputs quiet in and right after reset
  task automatic test_reset();
    repeat (3) @(negedge clk_bit);
    chk("R8 oe in reset", 32'(lane_oe), 32'd0);
    chk("R8 lanes in reset", 32'({lane_dat, lane_clk}), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk_bit);
    chk("R8 oe after release", 32'(lane_oe), 32'd0);
    chk("R8 lanes after release", 32'({lane_dat, lane_clk}), 32'd0);
  endtask

  // R2 R3 R4: several data patterns
  task automatic test_stream();
    send(21'h1FFFFF);
    send(21'h000000);
    send(21'h0AAAAA);
    send(21'h155555);
    send(21'h12345);
    send(21'h1C0E07);
  endtask

  // R1: last change just before the capturing edge wins
  task automatic test_late_change();
    wait_ph(0);
    pix_word = 21'h0F0F0F;
    wait_ph(4);
    pix_word = 21'h1B3C5A;
    check_frame("R1 late change", 21'h1B3C5A);
  endtask

  // R5: change after capture leaves the frame alone
  task automatic test_hold();
    wait_ph(0);
    pix_word = 21'h07F00F;
    wait_ph(5);
    pix_word = 21'h1807F0;
    check_frame("R5 change after capture", 21'h07F00F);
    send(21'h1807F0);
  endtask

  // R6: power-down releases the lanes on the next edge
  task automatic test_powerdown();
    logic stayed;
    wait_ph(2);
    pd_n = 1'b0;
    @(negedge clk_bit);
    chk("R6 oe after pd", 32'(lane_oe), 32'd0);
    chk("R6 lanes after pd", 32'({lane_dat, lane_clk}), 32'd0);
    stayed = 1'b1;
    for (int k = 0; k < 14; k++) begin
      if (k == 5) pix_word = 21'h155AA5;
      @(negedge clk_bit);
      stayed &= ~lane_oe & ~lane_clk & (lane_dat == 3'b000);
    end
    chk("R6 held off in pd", 32'(stayed), 32'd1);
  endtask

  // R7: enable returns only with the first complete frame
  task automatic test_release();
    logic stayed;
    wait_ph(0);
    pix_word = 21'h0C3A96;
    wait_ph(5);
    pd_n = 1'b1;
    stayed = 1'b1;
    for (int k = 0; k < 7; k++) begin
      @(negedge clk_bit);
      stayed &= ~lane_oe;
    end
    chk("R7 oe low until frame", 32'(stayed), 32'd1);
    check_frame("R7 first frame", 21'h0C3A96);
  endtask

  initial begin
    rst_n    = 1'b0;
    pd_n     = 1'b1;
    pix_word = '0;
    test_reset();
    test_stream();
    test_late_change();
    test_hold();
    test_powerdown();
    test_release();
    send(21'h1E1E1E);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_bit);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule